// File: doc/BRIEF.md
# Video Frame Buffer Write Address Generator

This block turns a stream of captured 32-bit pixel words into byte addresses for an external frame buffer. Four configuration values come from host-held registers: the buffer base, the buffer size in bytes, the line pitch (stride) in bytes, and the number of bytes written on each line. Three single-cycle strobes drive it: frame start, line start and word valid. For every valid word the block emits, one cycle later, a word-aligned byte address and a write-enable. The memory bus itself sits outside the block.

Line n of a frame begins at base + n × stride, whatever the visible byte count is, so a narrow image can sit inside a wider display pitch. Words past the visible byte count of a line are dropped. A word whose address falls outside the window [base, base + size) is also dropped. A dropped word keeps its address on the output, but its write-enable stays low.

Top module: `vbuf_addr_gen`

## Requirements
- R1: While `rst_ni` is low, `wr_en_o` is 0. After reset, and before any strobe, the first valid word is placed at the base address, in line 0, at offset 0.
- R2: Every emitted address has bits 1..0 equal to 0. Bits 1..0 of the base and size inputs have no effect on addresses or on clipping.
- R3: After a frame-start strobe, the next word is placed at the base address, even if it arrives in the middle of a line. The next line-start strobe then opens line 0.
- R4: The first line-start after frame start (or after reset) keeps the line base at the base address. Each later line-start moves the line base forward by the stride.
- R5: A line-start resets the in-line offset to 0. Within a line, each written word is 4 bytes above the previous one.
- R6: A word whose in-line offset is at or above the visible byte count has `wr_en_o` low. A visible count of 0 drops every word.
- R7: A word whose offset from the base (line base + in-line offset) is at or above the size (with bits 1..0 cleared) has `wr_en_o` low. A size of 0 drops every word.
- R8: `wr_en_o` and `wr_addr_o` are registered. A write shows in the cycle after its `word_valid_i`, and `wr_en_o` is low in every cycle that does not follow a valid word.
- R9: Strobe priority is frame start first, then line start, then word valid. A word valid in the same cycle as either strobe is dropped. A line-start in the same cycle as a frame-start is ignored, so line 0 opens on the next line-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_addr_i | input | 32 | Byte address of pixel (0,0) |
| buf_size_i | input | 21 | Buffer window size in bytes |
| line_stride_i | input | 13 | Byte distance between line starts (multiple of 4) |
| vis_bytes_i | input | 12 | Bytes written per line |
| frame_start_i | input | 1 | Frame start strobe |
| line_start_i | input | 1 | Line start strobe |
| word_valid_i | input | 1 | A 32-bit data word is present this cycle |
| wr_addr_o | output | 32 | Byte address of the write, bits 1..0 zero |
| wr_en_o | output | 1 | Write enable for `wr_addr_o` |

## Verification
A line base that is wrong shows up as an address error on the first write of the following line. The sweep reveals it one cycle after that word, at the first line boundary after the fault. An offset counter that is wrong, or fails to stop, shows up as a wrong address or a wrong enable on the next word of the same line. A clipping compare that is off by one changes the enable on exactly one word, the word at the window edge, in the line that crosses it. The sweep over sizes puts that word in many different lines. A strobe-priority fault causes a stray write in the cycle after a coincident strobe.

// File: rtl/vbuf_pkg.sv
package vbuf_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned SIZE_W     = 21;
  localparam int unsigned STRIDE_W   = 13;
  localparam int unsigned VIS_W      = 12;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_FRAME = 2'd1,
    EV_LINE  = 2'd2,
    EV_WORD  = 2'd3
  } vbuf_ev_e;
endpackage

// File: rtl/vbuf_evt_dec.sv
module vbuf_evt_dec
  import vbuf_pkg::*;
(
  input  logic     frame_start_i,
  input  logic     line_start_i,
  input  logic     word_valid_i,
  output vbuf_ev_e ev_o
);
  // frame > line > word
  always_comb begin
    if (frame_start_i)     ev_o = EV_FRAME;
    else if (line_start_i) ev_o = EV_LINE;
    else if (word_valid_i) ev_o = EV_WORD;
    else                   ev_o = EV_NONE;
  end
endmodule

// File: rtl/vbuf_line_track.sv
module vbuf_line_track
  import vbuf_pkg::*;
#(
  parameter int unsigned SIZE_W   = vbuf_pkg::SIZE_W,
  parameter int unsigned STRIDE_W = vbuf_pkg::STRIDE_W,
  localparam int unsigned REL_W   = SIZE_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  vbuf_ev_e            ev_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [SIZE_W-1:0]   size_eff_i,
  output logic [REL_W-1:0]    base_o
);
  logic [REL_W-1:0] base_q;
  logic             armed_q;

  // base stops once past the window, so REL_W never wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      unique case (ev_i)
        EV_FRAME: begin
          base_q  <= '0;
          armed_q <= 1'b1;
        end
        EV_LINE: begin
          if (armed_q) armed_q <= 1'b0;
          else if (base_q < REL_W'(size_eff_i)) base_q <= base_q + REL_W'(stride_i);
        end
        default: ;
      endcase
    end
  end

  assign base_o = base_q;
endmodule

// File: rtl/vbuf_word_track.sv
module vbuf_word_track
  import vbuf_pkg::*;
#(
  parameter int unsigned VIS_W = vbuf_pkg::VIS_W,
  localparam int unsigned OFS_W = VIS_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  vbuf_ev_e         ev_i,
  input  logic [VIS_W-1:0] vis_bytes_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic             vis_ok_o
);
  logic [OFS_W-1:0] ofs_q;

  assign vis_ok_o = ofs_q < OFS_W'(vis_bytes_i);

  // offset halts at the visible limit: dropped words do not advance it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q <= '0;
    end else begin
      unique case (ev_i)
        EV_FRAME, EV_LINE: ofs_q <= '0;
        EV_WORD: if (vis_ok_o) ofs_q <= ofs_q + OFS_W'(WORD_BYTES);
        default: ;
      endcase
    end
  end

  assign ofs_o = ofs_q;
endmodule

// File: rtl/vbuf_window_gate.sv
module vbuf_window_gate
  import vbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = vbuf_pkg::ADDR_W,
  parameter int unsigned SIZE_W = vbuf_pkg::SIZE_W,
  parameter int unsigned VIS_W  = vbuf_pkg::VIS_W,
  localparam int unsigned REL_W = SIZE_W + 1,
  localparam int unsigned OFS_W = VIS_W + 1,
  localparam int unsigned SUM_W = REL_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  vbuf_ev_e          ev_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [SIZE_W-1:0] size_eff_i,
  input  logic [REL_W-1:0]  base_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              vis_ok_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              en_o
);
  logic [SUM_W-1:0]  rel;
  logic              in_win;
  logic [ADDR_W-1:0] abs_addr;
  logic [ADDR_W-1:0] addr_q;
  logic              en_q;
  logic              unused_lsb;

  assign rel        = SUM_W'(base_i) + SUM_W'(ofs_i);
  assign in_win     = rel < SUM_W'(size_eff_i);
  assign abs_addr   = {start_i[ADDR_W-1:2], 2'b00} + ADDR_W'(rel);
  assign unused_lsb = ^abs_addr[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      en_q   <= 1'b0;
    end else if (ev_i == EV_WORD) begin
      addr_q <= {abs_addr[ADDR_W-1:2], 2'b00};
      en_q   <= vis_ok_i & in_win;
    end else begin
      en_q   <= 1'b0;
    end
  end

  assign addr_o = addr_q;
  assign en_o   = en_q;
endmodule

// File: rtl/vbuf_addr_gen.sv
module vbuf_addr_gen
  import vbuf_pkg::*;
#(
  parameter int unsigned ADDR_W   = vbuf_pkg::ADDR_W,
  parameter int unsigned SIZE_W   = vbuf_pkg::SIZE_W,
  parameter int unsigned STRIDE_W = vbuf_pkg::STRIDE_W,
  parameter int unsigned VIS_W    = vbuf_pkg::VIS_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   start_addr_i,
  input  logic [SIZE_W-1:0]   buf_size_i,
  input  logic [STRIDE_W-1:0] line_stride_i,
  input  logic [VIS_W-1:0]    vis_bytes_i,
  input  logic                frame_start_i,
  input  logic                line_start_i,
  input  logic                word_valid_i,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic                wr_en_o
);
  localparam int unsigned REL_W = SIZE_W + 1;
  localparam int unsigned OFS_W = VIS_W + 1;

  vbuf_ev_e          ev;
  logic [SIZE_W-1:0] size_eff;
  logic [REL_W-1:0]  line_base;
  logic [OFS_W-1:0]  line_ofs;
  logic              vis_ok;
  logic              unused_size_lsb;

  assign size_eff        = {buf_size_i[SIZE_W-1:2], 2'b00};
  assign unused_size_lsb = ^buf_size_i[1:0];

  vbuf_evt_dec u_dec (
    .frame_start_i (frame_start_i),
    .line_start_i  (line_start_i),
    .word_valid_i  (word_valid_i),
    .ev_o          (ev)
  );

  vbuf_line_track #(.SIZE_W(SIZE_W), .STRIDE_W(STRIDE_W)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev),
    .stride_i   (line_stride_i),
    .size_eff_i (size_eff),
    .base_o     (line_base)
  );

  vbuf_word_track #(.VIS_W(VIS_W)) u_word (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_i        (ev),
    .vis_bytes_i (vis_bytes_i),
    .ofs_o       (line_ofs),
    .vis_ok_o    (vis_ok)
  );

  vbuf_window_gate #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .VIS_W(VIS_W)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev),
    .start_i    (start_addr_i),
    .size_eff_i (size_eff),
    .base_i     (line_base),
    .ofs_i      (line_ofs),
    .vis_ok_i   (vis_ok),
    .addr_o     (wr_addr_o),
    .en_o       (wr_en_o)
  );
endmodule

// File: rtl/vbuf_addr_gen_chk.sv
module vbuf_addr_gen_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic [SIZE_W-1:0] buf_size_i,
  input logic              frame_start_i,
  input logic              line_start_i,
  input logic              word_valid_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              wr_en_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i) !rst_ni |-> !wr_en_o);

  assert_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o[1:0] == 2'b00));

  assert_in_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ((wr_addr_o - {$past(start_addr_i[ADDR_W-1:2]), 2'b00})
                 < ADDR_W'({$past(buf_size_i[SIZE_W-1:2]), 2'b00})));

  assert_en_follows_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(word_valid_i));

  assert_strobe_drops_word_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && (frame_start_i || line_start_i)) |=> !wr_en_o);
endmodule

bind vbuf_addr_gen vbuf_addr_gen_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_addr_i  (start_addr_i),
  .buf_size_i    (buf_size_i),
  .frame_start_i (frame_start_i),
  .line_start_i  (line_start_i),
  .word_valid_i  (word_valid_i),
  .wr_addr_o     (wr_addr_o),
  .wr_en_o       (wr_en_o)
);

// File: tb/test_vbuf_addr_gen.sv
module test_vbuf_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [31:0] start_addr_i = '0;
  logic [20:0] buf_size_i = '0;
  logic [12:0] line_stride_i = '0;
  logic [11:0] vis_bytes_i = '0;
  logic        frame_start_i = 1'b0;
  logic        line_start_i = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [31:0] wr_addr_o;
  logic        wr_en_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vbuf_addr_gen i_vbuf_addr_gen (
    .clk_i, .rst_ni, .start_addr_i, .buf_size_i, .line_stride_i, .vis_bytes_i,
    .frame_start_i, .line_start_i, .word_valid_i, .wr_addr_o, .wr_en_o
  );

  task automatic step(input logic fs, input logic ls, input logic wv);
    frame_start_i = fs;
    line_start_i  = ls;
    word_valid_i  = wv;
    @(negedge clk_i);
    frame_start_i = 1'b0;
    line_start_i  = 1'b0;
    word_valid_i  = 1'b0;
  endtask

  task automatic chk_en(input string req, input logic exp);
    checks++;
    if (wr_en_o !== exp) begin
      fails++;
      $display("FAIL %s wr_en_o actual=%b expected=%b", req, wr_en_o, exp);
    end
  endtask

  task automatic chk_wr(input string req, input logic exp_en, input logic [31:0] exp_addr);
    chk_en(req, exp_en);
    if (exp_en) begin
      checks++;
      if (wr_addr_o !== exp_addr) begin
        fails++;
        $display("FAIL %s wr_addr_o actual=%h expected=%h", req, wr_addr_o, exp_addr);
      end
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] st, input int rel);
    return ((st & 32'hFFFF_FFFC) + 32'(rel)) & 32'hFFFF_FFFC;
  endfunction

  initial begin
    #(WATCHDOG_CYCLES * CLK_PERIOD);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    static logic [31:0] starts[2]  = '{32'h0000_1000, 32'h0002_0003};
    static int          strides[2] = '{8, 20};
    static int          viss[3]    = '{0, 8, 12};
    static int          sizes[3]   = '{'h1e, 'h40, 0};

    #1 rst_ni = 1'b0;
    start_addr_i  = 32'h0000_0400;
    buf_size_i    = 21'h100;
    line_stride_i = 13'd32;
    vis_bytes_i   = 12'd16;
    word_valid_i  = 1'b1;
    repeat (3) @(negedge clk_i);
    chk_en("R1", 1'b0);             // held low through reset despite word_valid
    word_valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_en("R1", 1'b0);

    // R1: first word after reset lands at base
    step(0, 0, 1); chk_wr("R1", 1'b1, 32'h400);
    step(0, 0, 1); chk_wr("R5", 1'b1, 32'h404);
    step(0, 0, 0); chk_en("R8", 1'b0);
    // R4: first line start after reset keeps line 0
    step(0, 1, 0); chk_en("R8", 1'b0);
    step(0, 0, 1); chk_wr("R4", 1'b1, 32'h400);
    step(0, 1, 0);
    step(0, 0, 1); chk_wr("R4", 1'b1, 32'h420);

    // sweep over configurations
    foreach (starts[a]) foreach (strides[b]) foreach (viss[c]) foreach (sizes[d]) begin
      int size_eff;
      start_addr_i  = starts[a];
      line_stride_i = 13'(strides[b]);
      vis_bytes_i   = 12'(viss[c]);
      buf_size_i    = 21'(sizes[d]);
      size_eff      = sizes[d] & ~3;
      step(1, 0, 0); chk_en("R8", 1'b0);
      for (int n = 0; n < 4; n++) begin
        step(0, 1, 0); chk_en("R8", 1'b0);
        for (int k = 0; k < viss[c] / 4 + 2; k++) begin
          int rel;
          logic e;
          rel = n * strides[b] + 4 * k;
          e = (4 * k < viss[c]) && (rel < size_eff);
          step(0, 0, 1);
          if (4 * k >= viss[c]) chk_en("R6", 1'b0);
          else if (rel >= size_eff) chk_en("R7", 1'b0);
          else chk_wr("R5", e, exp_addr(starts[a], rel));
        end
      end
      // R3: frame start in mid line returns to base
      step(0, 0, 1);
      step(1, 0, 0);
      step(0, 0, 1);
      chk_wr("R3", (viss[c] > 0) && (size_eff > 0), exp_addr(starts[a], 0));
      step(0, 1, 0);
      step(0, 0, 1);
      chk_wr("R3", (viss[c] > 0) && (size_eff > 0), exp_addr(starts[a], 0));
    end

    // R2: low bits of base and size have no effect
    start_addr_i = 32'h0000_5003; buf_size_i = 21'h0B; line_stride_i = 13'd4; vis_bytes_i = 12'd16;
    step(1, 0, 0);
    step(0, 1, 0);
    step(0, 0, 1); chk_wr("R2", 1'b1, 32'h5000);
    step(0, 0, 1); chk_wr("R2", 1'b1, 32'h5004);
    step(0, 0, 1); chk_en("R2", 1'b0);  // offset 8 >= size 8

    // R9: strobe priority
    start_addr_i = 32'h0000_8000; buf_size_i = 21'h200; line_stride_i = 13'd64; vis_bytes_i = 12'd32;
    step(1, 1, 1); chk_en("R9", 1'b0);
    step(0, 1, 0);                      // opens line 0
    step(0, 0, 1); chk_wr("R9", 1'b1, 32'h8000);
    step(0, 1, 1); chk_en("R9", 1'b0);  // line 1 opens, word dropped
    step(0, 0, 1); chk_wr("R9", 1'b1, 32'h8040);
    step(1, 0, 1); chk_en("R9", 1'b0);
    step(0, 1, 0);
    step(0, 0, 1); chk_wr("R9", 1'b1, 32'h8000);
    step(0, 0, 0); chk_en("R8", 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule